// File: doc/BRIEF.md
# Wide Bus Send Byte Pairing Packer

This block sits on the send side of a data mover that reads bytes from memory and drives a 16-bit data bus. A move is started with a byte count and a chained bit. The block then accepts exactly that many bytes on a byte stream with valid/ready handshake. It pairs consecutive bytes into bus words, with the earlier byte in the low lane. Each word leaves through a registered word port that has its own valid/ready handshake and per-lane byte enables.

A move can end with an odd, unpaired low byte. In a normal move that byte goes out alone as a partial word, with only the low-lane enable asserted. In a chained move the byte stays in an internal latch and the hold flag is raised. The next move, chained or normal, pairs its first byte with the latched byte as the high half of a full word, and the flag drops.

A one-cycle done pulse marks the end of every move. This lets a sequencer issue N consecutive send moves, with all but the last one chained.

Top module: `wide_send_packer`

## Requirements
- R1: The byte count gives the number of bytes accepted on the byte input, not the number of bytes sent on the bus. After the last counted byte, in_ready stays low until a new move starts.
- R2: Each full word carries the earlier stream byte in bits 7:0 and the later byte in bits 15:8.
- R3: When a chained move ends on an unpaired byte, that byte is not sent. It is kept in the latch and hold_flag reads 1.
- R4: When hold_flag is 1 at the start of any move, chained or normal, the move's first byte goes out in bits 15:8 together with the latched byte in bits 7:0. hold_flag then reads 0.
- R5: When a normal move ends on an unpaired byte, that byte is sent as a partial word in bits 7:0, with bits 15:8 zero and hold_flag left at 0.
- R6: out_be is 2'b11 for a full word and 2'b01 for a partial word. No other value appears while out_valid is 1.
- R7: done is high for exactly the cycle after the clock edge that accepts the move's last byte. A start with count 0 transfers nothing and pulses done in the cycle after the start.
- R8: While out_valid is 1 and out_ready is 0, the word and its enables hold steady and no byte is accepted. No byte is lost or duplicated under any backpressure pattern.
- R9: Reset clears hold_flag, out_valid, in_ready and done.
- R10: A chained move of five bytes with hold_flag clear emits two full words and leaves the fifth byte latched with hold_flag 1.
- R11: cmd_start while a move is in progress is ignored. The running move keeps its original count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start a move, sampled only when idle |
| cmd_count | input | CNT_W | Bytes to take from memory for the move |
| cmd_chain | input | 1 | 1 = chained move, hold an odd trailing byte |
| in_data | input | 8 | Memory byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Byte is accepted when valid and ready |
| out_word | output | 16 | Bus word, earlier byte in the low lane |
| out_be | output | 2 | Per-lane byte enables, bit 0 = low lane |
| out_valid | output | 1 | out_word holds a word |
| out_ready | input | 1 | Bus side takes the word |
| done | output | 1 | One-cycle end-of-move pulse |
| hold_flag | output | 1 | A low byte waits in the latch to be paired |

## Verification
Two things can fall in the same clock edge. The word register can hand off a word to the bus side while an incoming byte completes a new word for it. Likewise, the last byte of a move can be accepted, and either latched or sent, while an earlier word is still stalled or draining. The bench provokes both with a sweep of counts 0 to 6, both chain settings, and four out_ready patterns (always, alternating, one in three, pseudo-random), running the moves back to back so that the hold state carries from one move to the next. Every emitted word and its enables are compared against a byte-level arithmetic model. The done pulse is judged against the cycle in which the bench saw the last handshake.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = 2 * LANE_W;
  localparam logic [1:0]  BE_FULL = 2'b11;
  localparam logic [1:0]  BE_LOW  = 2'b01;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [WORD_W-1:0] word_t;

  // earlier byte goes to the low lane
  function automatic word_t marry(input lane_t first_b, input lane_t second_b);
    return {second_b, first_b};
  endfunction

  function automatic logic at_last(input logic [31:0] remaining);
    return remaining == 32'd1;
  endfunction
endpackage

// File: rtl/wsp_move_ctrl.sv
module wsp_move_ctrl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             cmd_chain,
  input  logic             in_valid,
  input  logic             slot_free,
  output logic             in_ready,
  output logic             byte_take,
  output logic             last_take,
  output logic             chain_act,
  output logic             done
);
  import wsp_pkg::*;

  logic             active_q;
  logic [CNT_W-1:0] rem_q;
  logic             chain_q;
  logic             done_q;
  logic             start_ok;
  logic             zero_start;

  assign start_ok   = cmd_start && !active_q;
  assign zero_start = start_ok && (cmd_count == '0);
  assign in_ready   = active_q && slot_free;
  assign byte_take  = in_valid && in_ready;
  assign last_take  = byte_take && at_last(32'(rem_q));
  assign chain_act  = chain_q;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rem_q    <= '0;
      chain_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_take || zero_start;
      if (start_ok && !zero_start) begin
        active_q <= 1'b1;
        rem_q    <= cmd_count;
        chain_q  <= cmd_chain;
      end else if (byte_take) begin
        rem_q <= rem_q - 1'b1;
        if (last_take) active_q <= 1'b0;
      end
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> done); // R7
  AST_COUNT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> !in_ready); // R1
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cmd_start && !byte_take) |=> $stable(rem_q)); // R11
endmodule

// File: rtl/wsp_pair_dp.sv
module wsp_pair_dp (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            in_data,
  input  logic                  byte_take,
  input  logic                  last_take,
  input  logic                  chain_act,
  input  logic                  out_ready,
  output logic                  slot_free,
  output logic [15:0]           out_word,
  output logic [1:0]            out_be,
  output logic                  out_valid,
  output logic                  hold_flag,
  output logic                  emit_full,
  output logic                  emit_part
);
  import wsp_pkg::*;

  lane_t       lo_q;
  logic        lo_v_q;
  word_t       word_q;
  logic [1:0]  be_q;
  logic        val_q;
  logic        latch_byte;

  assign slot_free  = !val_q || out_ready;
  assign emit_full  = byte_take && lo_v_q;
  assign emit_part  = byte_take && !lo_v_q && last_take && !chain_act;
  assign latch_byte = byte_take && !emit_full && !emit_part;

  assign out_word  = word_q;
  assign out_be    = be_q;
  assign out_valid = val_q;
  assign hold_flag = lo_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      be_q   <= '0;
      val_q  <= 1'b0;
    end else if (emit_full || emit_part) begin
      val_q  <= 1'b1;
      word_q <= emit_full ? marry(lo_q, in_data) : marry(in_data, '0);
      be_q   <= emit_full ? BE_FULL : BE_LOW;
    end else if (out_ready) begin
      val_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      lo_v_q <= 1'b0;
    end else if (emit_full) begin
      lo_v_q <= 1'b0;
    end else if (latch_byte) begin
      lo_q   <= in_data;
      lo_v_q <= 1'b1;
    end
  end

  AST_PAIR_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    emit_full |=> !hold_flag); // R4
  AST_CHAIN_TAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take && chain_act && !hold_flag) |=> hold_flag); // R3
  AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_be == 2'b11 || out_be == 2'b01)); // R6
  AST_PART_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_be == 2'b01) |-> (out_word[15:8] == 8'h00)); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_be))); // R8
endmodule

// File: rtl/wide_send_packer.sv
module wide_send_packer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             cmd_chain,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [15:0]      out_word,
  output logic [1:0]       out_be,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             done,
  output logic             hold_flag
);
  logic slot_free;
  logic byte_take;
  logic last_take;
  logic chain_act;
  logic emit_full;
  logic emit_part;

  wsp_move_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_count (cmd_count),
    .cmd_chain (cmd_chain),
    .in_valid  (in_valid),
    .slot_free (slot_free),
    .in_ready  (in_ready),
    .byte_take (byte_take),
    .last_take (last_take),
    .chain_act (chain_act),
    .done      (done)
  );

  wsp_pair_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .byte_take (byte_take),
    .last_take (last_take),
    .chain_act (chain_act),
    .out_ready (out_ready),
    .slot_free (slot_free),
    .out_word  (out_word),
    .out_be    (out_be),
    .out_valid (out_valid),
    .hold_flag (hold_flag),
    .emit_full (emit_full),
    .emit_part (emit_part)
  );

  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (!out_valid || out_ready)); // R8
  AST_ONE_EMIT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(emit_full && emit_part)); // R6
endmodule

// File: tb/wide_send_packer_bench.sv
module wide_send_packer_bench;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_start = 1'b0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic             cmd_chain = 1'b0;
  logic [7:0]       in_data = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [15:0]      out_word;
  logic [1:0]       out_be;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic             done;
  logic             hold_flag;

  always #2 clk = ~clk;

  wide_send_packer #(.CNT_W(CNT_W)) u_wide_send_packer (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_count(cmd_count),
    .cmd_chain(cmd_chain), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_word(out_word), .out_be(out_be),
    .out_valid(out_valid), .out_ready(out_ready), .done(done),
    .hold_flag(hold_flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  int gb = 0;
  logic [7:0] lfsr = 8'hA5;
  bit   m_hold = 1'b0;
  logic [7:0] m_lo = '0;
  logic [17:0] expq[$];
  int words_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_val(input int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  // reference model of one accepted byte
  task automatic model_byte(input logic [7:0] b, input bit last, input bit ch);
    if (m_hold) begin
      expq.push_back({2'b11, b, m_lo});
      m_hold = 1'b0;
    end else if (last && !ch) begin
      expq.push_back({2'b01, 8'h00, b});
    end else begin
      m_lo = b;
      m_hold = 1'b1;
    end
  endtask

  function automatic bit ready_pat(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return cyc[0];
      2: return (cyc % 3) == 0;
      default: return lfsr[0];
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_move(input int n, input bit ch, input int mode, input bit poke);
    int fed; int cyc; bit pend; bit seen; logic [17:0] e;
    fed = 0; cyc = 0; pend = 0; seen = 0; words_seen = 0;
    @(negedge clk);
    cmd_start = 1'b1; cmd_count = CNT_W'(n); cmd_chain = ch;
    @(negedge clk);
    cmd_start = 1'b0;
    if (n == 0) begin
      chk(done === 1'b1, "R7", "done after zero-count start", 32'(done), 1);
      chk(in_ready === 1'b0, "R7", "no transfer on zero count", 32'(in_ready), 0);
      return;
    end
    while (!(seen && expq.size() == 0)) begin
      if (done !== pend) chk(1'b0, "R7", "done timing", 32'(done), 32'(pend));
      else if (pend) begin chk(1'b1, "R7", "done", 1, 1); seen = 1; end
      pend = 0;
      cmd_start = poke && (cyc == 2);
      cmd_count = CNT_W'(1);
      in_valid = 1'b1;
      in_data = byte_val(gb);
      out_ready = ready_pat(mode, cyc);
      #1;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R8", "unexpected word", 32'(out_word), 0);
        else begin
          e = expq.pop_front();
          chk({out_be, out_word} === e, (e[17:16] == 2'b01) ? "R5" : "R2",
              "word and enables", 32'({out_be, out_word}), 32'(e));
          words_seen++;
        end
      end
      if (in_valid && in_ready) begin
        if (fed >= n) chk(1'b0, poke ? "R11" : "R1", "byte beyond count", fed + 1, n);
        else begin
          model_byte(in_data, fed == n - 1, ch);
          fed++; gb++;
          pend = (fed == n);
        end
      end
      cyc++;
      if (cyc > 400) begin
        chk(1'b0, "R8", "move stalled", 32'(fed), 32'(n));
        break;
      end
      @(negedge clk);
    end
    cmd_start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    chk(fed == n, poke ? "R11" : "R1", "bytes accepted", 32'(fed), 32'(n));
    chk(hold_flag === m_hold, m_hold ? "R3" : "R4", "hold flag after move",
        32'(hold_flag), 32'(m_hold));
  endtask

  initial begin
    #1;
    chk(hold_flag === 1'b0 && out_valid === 1'b0 && in_ready === 1'b0 && done === 1'b0,
        "R9", "reset outputs", {hold_flag, out_valid, in_ready, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: chained five bytes from clear
    run_move(5, 1'b1, 0, 1'b0);
    chk(words_seen == 2, "R10", "words for chained five", 32'(words_seen), 2);
    chk(hold_flag === 1'b1, "R10", "fifth byte latched", 32'(hold_flag), 1);
    chk(out_valid === 1'b0, "R3", "latched byte not sent", 32'(out_valid), 0);

    // R9: reset drops a held byte
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(hold_flag === 1'b0, "R9", "reset clears hold", 32'(hold_flag), 0);
    m_hold = 1'b0;
    rst_n = 1'b1;

    // R4 with a normal move after a held byte; R6 via enables
    run_move(3, 1'b1, 0, 1'b0);
    run_move(2, 1'b0, 1, 1'b0);

    // R11: start pulse during a move
    run_move(4, 1'b0, 0, 1'b1);
    run_move(5, 1'b1, 2, 1'b1);

    // sweep: backpressure modes x chain x count, hold carried across moves
    for (int mode = 0; mode < 4; mode++)
      for (int ch = 0; ch < 2; ch++)
        for (int n = 0; n < 7; n++)
          run_move(n, ch[0], mode, 1'b0);

    // R6/R8: long moves under random stalls
    run_move(17, 1'b1, 3, 1'b0);
    run_move(16, 1'b0, 3, 1'b0);
    run_move(9, 1'b0, 2, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule